// File: doc/BRIEF.md
# RAM ECC Error and Link Event Reporter

This unit gathers correctable (single-bit) and uncorrectable (double-bit) error reports from four buffer RAMs, each with four lanes: transmit, receive, PCIe-to-bus and bus-to-PCIe. It also collects three link events: exit from L2, exit from hot reset and data link up. Each report sets a sticky status bit. Software reads and clears these bits through a 32-bit register port, masks them from the single interrupt line, and keeps a saturating count of error cycles for each error class. The same register port drives the ECC error-injection levels and the per-RAM ECC bypass controls that go to the RAM codecs.

The register port is a simple write strobe with a byte address and write data. Read data is combinational from the address. Unmapped offsets read as zero. Error pulses are sampled on every rising clock edge. Link event pulses are sampled the same way.

Top module: `ram_err_event_unit`

## Requirements
- R1: After reset, all status bits, both counters, all injection bits and all bypass bits are 0. Both error masks read 0x0000FFFF. The link register reads 0x00070000 (all three link events masked). The irq output is 0.
- R2: An error pulse on lane L of RAM r sets status bit 4*r+L in the cycle after it is seen. RAM r is 0 for transmit, 1 for receive, 2 for PCIe-to-bus and 3 for bus-to-PCIe. Single-bit errors go to the status word at 0x28 and double-bit errors go to the status word at 0x30. The bit stays set until it is cleared.
- R3: Writing 1 to a bit of 0x28 or 0x30 clears that bit. Writing 0 to a bit leaves it unchanged. A pulse arriving in the same cycle as the clearing write wins, so the bit stays set.
- R4: irq is 1 exactly when some status bit is set and its mask bit is 0. The masks are at 0x2C for single-bit errors, at 0x34 for double-bit errors, and at bits 18:16 of 0x14C for link events. A mask bit of 1 blocks its status bit.
- R5: The counter at 0x20 (single-bit) and the counter at 0x24 (double-bit) each rise by exactly one in every cycle in which at least one unbypassed input of their class is asserted. The count does not depend on how many inputs are asserted.
- R6: A counter that holds all ones stays at all ones while further errors arrive.
- R7: Writing zero to a counter clears it, and this takes precedence over an increment in the same cycle. Writing a nonzero value to a counter has no effect.
- R8: The control word at 0x38 holds the injection bits at 15:0, with the same RAM/lane layout as the status words, and the bypass bits at 24+r. These bits drive ecc_inject and ecc_bypass as held levels that only a new write changes. The control word reads back as written.
- R9: While bypass bit r is set, the error inputs of RAM r set no status bit and count nothing, for both single-bit and double-bit errors.
- R10: link_evt[0] (L2 exit), link_evt[1] (hot reset exit) and link_evt[2] (link up) set bits 0 to 2 of 0x14C. Writing 1 to one of these bits clears it. Bits 18:16 of a write to 0x14C replace the link masks.
- R11: Reads of unmapped offsets, and of the unused bits of mapped words, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW (12) | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| sec_err | input | RAMS*LANES (16) | Single-bit error pulses, one per RAM lane |
| ded_err | input | RAMS*LANES (16) | Double-bit error pulses, one per RAM lane |
| link_evt | input | 3 | Link event pulses: L2 exit, hot reset exit, link up |
| ecc_inject | output | RAMS*LANES (16) | Error injection levels to the codecs |
| ecc_bypass | output | RAMS (4) | ECC bypass level per RAM |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The bench pulses every one of the 32 error lanes alone and checks that exactly the expected status bit is set. This shows that the RAM/lane placement and the single-bit/double-bit split are correct, and that lanes do not alias. The same sweep drives the 4-bit counter past its limit, so the increment and saturation are checked together.

All-lanes pulses confirm that the counter advances by one per cycle, not one per bit. A single-bit unmask walk shows that each mask bit gates only its own status bit. A bypass walk over each RAM, with every lane firing, shows that only the lanes of the bypassed RAM are suppressed. Same-cycle collisions of a pulse with a clearing write, and of an increment with a counter clear, pin down the stated precedence.

// File: rtl/ram_err_event_unit.sv
module ram_err_event_unit #(
  parameter int RAMS  = 4,
  parameter int LANES = 4,
  parameter int CNT_W = 32,
  parameter int AW    = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [AW-1:0]         reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [RAMS*LANES-1:0] sec_err,
  input  logic [RAMS*LANES-1:0] ded_err,
  input  logic [2:0]            link_evt,
  output logic [RAMS*LANES-1:0] ecc_inject,
  output logic [RAMS-1:0]       ecc_bypass,
  output logic                  irq
);
  localparam int EW = RAMS * LANES;
  localparam logic [AW-1:0] A_SEC_CNT = AW'('h020);
  localparam logic [AW-1:0] A_DED_CNT = AW'('h024);
  localparam logic [AW-1:0] A_SEC_ST  = AW'('h028);
  localparam logic [AW-1:0] A_SEC_MSK = AW'('h02C);
  localparam logic [AW-1:0] A_DED_ST  = AW'('h030);
  localparam logic [AW-1:0] A_DED_MSK = AW'('h034);
  localparam logic [AW-1:0] A_CTRL    = AW'('h038);
  localparam logic [AW-1:0] A_LINK    = AW'('h14C);
  localparam int BYP_LSB = 24;
  localparam int LMSK_LSB = 16;

  logic [EW-1:0]    sec_st, ded_st, sec_msk, ded_msk, inj, byp_lanes, sec_in, ded_in;
  logic [RAMS-1:0]  byp;
  logic [2:0]       lnk_st, lnk_msk;
  logic [CNT_W-1:0] sec_cnt, ded_cnt;

  for (genvar r = 0; r < RAMS; r++) begin : g_byp
    assign byp_lanes[r*LANES +: LANES] = {LANES{byp[r]}};
  end

  assign sec_in = sec_err & ~byp_lanes;
  assign ded_in = ded_err & ~byp_lanes;

  wire wr_sec_cnt = reg_wr && reg_addr == A_SEC_CNT;
  wire wr_ded_cnt = reg_wr && reg_addr == A_DED_CNT;
  wire wr_sec_st  = reg_wr && reg_addr == A_SEC_ST;
  wire wr_sec_msk = reg_wr && reg_addr == A_SEC_MSK;
  wire wr_ded_st  = reg_wr && reg_addr == A_DED_ST;
  wire wr_ded_msk = reg_wr && reg_addr == A_DED_MSK;
  wire wr_ctrl    = reg_wr && reg_addr == A_CTRL;
  wire wr_link    = reg_wr && reg_addr == A_LINK;
  wire wzero      = reg_wdata == 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_st  <= '0;
      ded_st  <= '0;
      sec_msk <= '1;
      ded_msk <= '1;
      inj     <= '0;
      byp     <= '0;
      lnk_st  <= '0;
      lnk_msk <= '1;
    end else begin
      sec_st <= (wr_sec_st ? sec_st & ~reg_wdata[EW-1:0] : sec_st) | sec_in;
      ded_st <= (wr_ded_st ? ded_st & ~reg_wdata[EW-1:0] : ded_st) | ded_in;
      lnk_st <= (wr_link ? lnk_st & ~reg_wdata[2:0] : lnk_st) | link_evt;
      if (wr_sec_msk) sec_msk <= reg_wdata[EW-1:0];
      if (wr_ded_msk) ded_msk <= reg_wdata[EW-1:0];
      if (wr_link) lnk_msk <= reg_wdata[LMSK_LSB +: 3];
      if (wr_ctrl) begin
        inj <= reg_wdata[EW-1:0];
        byp <= reg_wdata[BYP_LSB +: RAMS];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
      ded_cnt <= '0;
    end else begin
      if (wr_sec_cnt && wzero) sec_cnt <= '0;
      else if (|sec_in && !(&sec_cnt)) sec_cnt <= sec_cnt + 1'b1;
      if (wr_ded_cnt && wzero) ded_cnt <= '0;
      else if (|ded_in && !(&ded_cnt)) ded_cnt <= ded_cnt + 1'b1;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SEC_CNT: reg_rdata = 32'(sec_cnt);
      A_DED_CNT: reg_rdata = 32'(ded_cnt);
      A_SEC_ST:  reg_rdata = 32'(sec_st);
      A_SEC_MSK: reg_rdata = 32'(sec_msk);
      A_DED_ST:  reg_rdata = 32'(ded_st);
      A_DED_MSK: reg_rdata = 32'(ded_msk);
      A_CTRL: begin
        reg_rdata = 32'(inj);
        reg_rdata[BYP_LSB +: RAMS] = byp;
      end
      A_LINK: begin
        reg_rdata[2:0] = lnk_st;
        reg_rdata[LMSK_LSB +: 3] = lnk_msk;
      end
      default: reg_rdata = '0;
    endcase
  end

  assign ecc_inject = inj;
  assign ecc_bypass = byp;
  assign irq = (|(sec_st & ~sec_msk)) | (|(ded_st & ~ded_msk)) | (|(lnk_st & ~lnk_msk));
endmodule

module ram_err_event_unit_chk #(
  parameter int RAMS  = 4,
  parameter int LANES = 4,
  parameter int CNT_W = 32,
  parameter int AW    = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  reg_wr,
  input logic [AW-1:0]         reg_addr,
  input logic [31:0]           reg_wdata,
  input logic [RAMS*LANES-1:0] sec_err,
  input logic [2:0]            link_evt,
  input logic [RAMS*LANES-1:0] ecc_inject,
  input logic [RAMS-1:0]       ecc_bypass,
  input logic                  irq,
  input logic [RAMS*LANES-1:0] sec_st,
  input logic [RAMS*LANES-1:0] ded_st,
  input logic [2:0]            lnk_st,
  input logic [CNT_W-1:0]      sec_cnt
);
  localparam logic [AW-1:0] A_SEC_CNT = AW'('h020);
  localparam logic [AW-1:0] A_SEC_ST  = AW'('h028);
  localparam logic [AW-1:0] A_CTRL    = AW'('h038);

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_st[0] && !(reg_wr && reg_addr == A_SEC_ST)) |=> sec_st[0]); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SEC_ST && reg_wdata[0] && !sec_err[0]) |=> !sec_st[0]); // R3
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_st == '0 && ded_st == '0 && lnk_st == '0) |-> !irq); // R4
  AST_CNT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_SEC_CNT && reg_wdata == 32'd0) |=> sec_cnt >= $past(sec_cnt)); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_SEC_CNT && reg_wdata == 32'd0) |=> sec_cnt == '0); // R7
  AST_INJ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_CTRL) |=> ecc_inject == $past(reg_wdata[RAMS*LANES-1:0])); // R8
  AST_INJ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == A_CTRL) |=> $stable(ecc_inject)); // R8
  AST_BYPASS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_bypass[0] && sec_st[LANES-1:0] == '0 && !(reg_wr && reg_addr == A_CTRL))
      |=> sec_st[LANES-1:0] == '0); // R9
  AST_LINK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt[0] |=> lnk_st[0]); // R10
endmodule

bind ram_err_event_unit ram_err_event_unit_chk #(
  .RAMS(RAMS), .LANES(LANES), .CNT_W(CNT_W), .AW(AW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .sec_err(sec_err), .link_evt(link_evt), .ecc_inject(ecc_inject), .ecc_bypass(ecc_bypass),
  .irq(irq), .sec_st(sec_st), .ded_st(ded_st), .lnk_st(lnk_st), .sec_cnt(sec_cnt)
);

// File: tb/ram_err_event_unit_bench.sv
`timescale 1ns/1ps
module ram_err_event_unit_bench;
  localparam int CW = 4;
  localparam logic [11:0] A_SEC_CNT = 12'h020, A_DED_CNT = 12'h024, A_SEC_ST = 12'h028,
    A_SEC_MSK = 12'h02C, A_DED_ST = 12'h030, A_DED_MSK = 12'h034, A_CTRL = 12'h038,
    A_LINK = 12'h14C;

  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [15:0] sec_err = 0, ded_err = 0, ecc_inject;
  logic [2:0] link_evt = 0;
  logic [3:0] ecc_bypass;
  logic irq;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  ram_err_event_unit #(.RAMS(4), .LANES(4), .CNT_W(CW), .AW(12)) u_ram_err_event_unit (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sec_err(sec_err), .ded_err(ded_err), .link_evt(link_evt),
    .ecc_inject(ecc_inject), .ecc_bypass(ecc_bypass), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] d, input logic [2:0] l);
    sec_err = s; ded_err = d; link_evt = l;
    @(negedge clk);
    sec_err = 0; ded_err = 0; link_evt = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 sec status", A_SEC_ST, 0);
    rd_chk("R1 ded status", A_DED_ST, 0);
    rd_chk("R1 sec mask", A_SEC_MSK, 32'h0000FFFF);
    rd_chk("R1 ded mask", A_DED_MSK, 32'h0000FFFF);
    rd_chk("R1 link word", A_LINK, 32'h00070000);
    rd_chk("R1 sec count", A_SEC_CNT, 0);
    rd_chk("R1 ded count", A_DED_CNT, 0);
    rd_chk("R1 control", A_CTRL, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 inject", 32'(ecc_inject), 0);

    // R2 R3 R5 R6 lane sweep over both classes
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < 16; i++) begin
        if (c == 0) pulse(16'(1 << i), 0, 0); else pulse(0, 16'(1 << i), 0);
        rd_chk("R2 lane status", c ? A_DED_ST : A_SEC_ST, 32'(1 << i));
        rd_chk("R2 other class clear", c ? A_SEC_ST : A_DED_ST, 0);
        rd_chk("R6 count saturating", c ? A_DED_CNT : A_SEC_CNT, (i + 1 > 15) ? 15 : i + 1);
        chk("R4 masked irq", 32'(irq), 0);
        wr(c ? A_DED_ST : A_SEC_ST, 32'(1 << i));
        rd_chk("R3 w1c", c ? A_DED_ST : A_SEC_ST, 0);
      end
    end

    // R7 counter write rules, R5 per-cycle counting
    wr(A_SEC_CNT, 0);
    rd_chk("R7 clear", A_SEC_CNT, 0);
    pulse(16'hFFFF, 0, 0);
    rd_chk("R5 one per cycle", A_SEC_CNT, 1);
    wr(A_SEC_CNT, 5);
    rd_chk("R7 nonzero ignored", A_SEC_CNT, 1);
    sec_err = 16'h0001; reg_wr = 1; reg_addr = A_SEC_CNT; reg_wdata = 0;
    @(negedge clk);
    sec_err = 0; reg_wr = 0;
    rd_chk("R7 clear beats increment", A_SEC_CNT, 0);
    // R3 set wins over clear
    sec_err = 16'h0008; reg_wr = 1; reg_addr = A_SEC_ST; reg_wdata = 32'hFFFF;
    @(negedge clk);
    sec_err = 0; reg_wr = 0;
    rd_chk("R3 set beats clear", A_SEC_ST, 32'h0008);
    wr(A_SEC_ST, 32'hFFFF);

    // R4 mask walk
    pulse(16'hFFFF, 16'hFFFF, 0);
    for (int i = 0; i < 16; i++) begin
      wr(A_SEC_MSK, 32'(~(1 << i) & 16'hFFFF));
      chk("R4 sec unmask", 32'(irq), 1);
      wr(A_SEC_MSK, 32'hFFFF);
      chk("R4 sec remask", 32'(irq), 0);
      wr(A_DED_MSK, 32'(~(1 << i) & 16'hFFFF));
      chk("R4 ded unmask", 32'(irq), 1);
      wr(A_DED_MSK, 32'hFFFF);
    end
    wr(A_SEC_ST, 32'hFFFF);
    wr(A_DED_ST, 32'hFFFF);
    wr(A_SEC_MSK, 0);
    chk("R4 empty status no irq", 32'(irq), 0);
    wr(A_SEC_MSK, 32'hFFFF);

    // R8 R9 bypass walk
    for (int r = 0; r < 4; r++) begin
      logic [31:0] cw;
      cw = 32'(1 << (24 + r)) | 32'(16'hA5A5 ^ 16'(r));
      wr(A_CTRL, cw);
      repeat (3) @(negedge clk);
      chk("R8 inject level", 32'(ecc_inject), 32'(16'hA5A5 ^ 16'(r)));
      chk("R8 bypass level", 32'(ecc_bypass), 32'(1 << r));
      rd_chk("R8 control readback", A_CTRL, cw);
      wr(A_SEC_CNT, 0);
      wr(A_DED_CNT, 0);
      pulse(16'hFFFF, 16'hFFFF, 0);
      rd_chk("R9 sec status bypassed", A_SEC_ST, 32'(16'hFFFF & ~(16'hF << (4 * r))));
      rd_chk("R9 ded status bypassed", A_DED_ST, 32'(16'hFFFF & ~(16'hF << (4 * r))));
      pulse(16'(16'hF << (4 * r)), 16'(16'hF << (4 * r)), 0);
      rd_chk("R9 sec count bypassed", A_SEC_CNT, 1);
      rd_chk("R9 ded count bypassed", A_DED_CNT, 1);
      wr(A_SEC_ST, 32'hFFFF);
      wr(A_DED_ST, 32'hFFFF);
    end
    wr(A_CTRL, 0);
    chk("R8 cleared", 32'(ecc_inject), 0);

    // R10 link events
    for (int k = 0; k < 3; k++) begin
      pulse(0, 0, 3'(1 << k));
      rd_chk("R10 link status", A_LINK, 32'h00070000 | 32'(1 << k));
      chk("R4 link masked", 32'(irq), 0);
      wr(A_LINK, 32'((~(1 << k) & 7) << 16));
      chk("R4 link unmasked", 32'(irq), 1);
      rd_chk("R10 status kept by zero write", A_LINK, 32'((~(1 << k) & 7) << 16) | 32'(1 << k));
      wr(A_LINK, 32'h00070000 | 32'(1 << k));
      rd_chk("R10 link w1c", A_LINK, 32'h00070000);
      chk("R10 irq after clear", 32'(irq), 0);
    end

    // R11 unmapped
    rd_chk("R11 unmapped 0x000", 12'h000, 0);
    rd_chk("R11 unmapped 0x03C", 12'h03C, 0);
    rd_chk("R11 unmapped 0x148", 12'h148, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule